// File: doc/BRIEF.md
# Banked Overlay Memory Decoder

This block lets a small on-chip RAM stand in for part of a target processor's 64 KB memory map. The RAM is split into two 4 KB windows, A and B. Each window has its own 4-bit base input that places it on one of the sixteen 4 KB-aligned regions of the address space. Each window also has its own 2-bit mode input that sets it off, read-only or read-write. On every bus cycle the block compares the upper address bits with both windows. When a window claims the cycle, the overlay answers it: the block raises a target-disable line that holds off the user system's memory, and it serves the access from the overlay RAM.

A read-only window behaves like ROM. Reads are served, and writes are swallowed: the target still sees its memory disabled, but the RAM keeps its contents. When both windows claim the same cycle, window A wins. Read data comes from a registered RAM port and appears on the cycle after the strobe, together with a valid flag. Outside that cycle the data bus is held at zero.

Top module: `ovl_decoder`

## Requirements
- R1: A window hits when it is enabled and bus_addr[15:12] equals its base. During a strobe (bus_rd or bus_wr high) that hits, tgt_disable is high and hit_bank gives the winning window (0 = A, 1 = B).
- R2: Mode code 2'b00 (off) and the reserved code 2'b11 disable a window, which then never hits. Code 2'b01 is read-only and 2'b10 is read-write.
- R3: A write that hits a read-only window raises tgt_disable and keeps ram_we and ram_cs low. A later read of that location returns the old byte.
- R4: A write that hits a read-write window raises ram_cs and ram_we and stores bus_wdata. A later read of the same address returns that byte.
- R5: When both windows are enabled and hit, window A serves the cycle (hit_bank = 0), and window B's storage is not touched.
- R6: The windows have separate storage. RAM byte index = {bank, bus_addr[11:0]}, so the same offset in A and in B holds different bytes.
- R7: A read hit (bus_rd high, bus_wr low) raises ram_cs in the strobe cycle. The byte appears on ovl_rdata with ovl_rdata_oe high on the following cycle only.
- R8: On a strobe that misses both windows, tgt_disable, ram_cs and ram_we stay low. On the next cycle ovl_rdata_oe is low and ovl_rdata is zero.
- R9: With no strobe, tgt_disable, ram_cs and ram_we are low whatever the address and modes.
- R10: After reset, ovl_rdata_oe is low and ovl_rdata is zero.
- R11: A cycle with bus_rd and bus_wr both high is treated as a write and produces no read data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Target bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| win_base | input | 8 | Window bases, A in [3:0], B in [7:4] |
| win_mode | input | 4 | Window modes, A in [1:0], B in [3:2] |
| tgt_disable | output | 1 | Holds off the user system memory for this cycle |
| ram_cs | output | 1 | Overlay RAM select |
| ram_we | output | 1 | Overlay RAM write enable |
| hit_bank | output | 1 | Window serving the current cycle |
| ovl_rdata | output | 8 | Overlay read data, zero when not valid |
| ovl_rdata_oe | output | 1 | Read data valid, one cycle after a read hit |

## Verification
The checker watches several rules on every cycle. Off and reserved modes never claim a cycle. An idle bus leaves the RAM and target controls low. A write to a read-only window never reaches the RAM. Window A wins whenever both windows match. Read-valid follows exactly one cycle after each read hit, and the data bus is zero whenever read-valid is low. The rules that need memory contents can only be shown by the bench's scenarios, which compare read data against a reference image of the RAM. These are that a write lands in the right window and offset, that a swallowed write leaves the old byte in place, and that an overlapped write spares window B.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   typedef enum logic [1:0] {
      OVL_OFF = 2'b00,
      OVL_RO  = 2'b01,
      OVL_RW  = 2'b10,
      OVL_RSV = 2'b11
   } ovl_mode_e;

   function automatic logic mode_live(input logic [1:0] m);
      return (m == OVL_RO) || (m == OVL_RW);
   endfunction

   function automatic logic mode_writable(input logic [1:0] m);
      return m == OVL_RW;
   endfunction

endpackage

// File: rtl/ovl_window.sv
module ovl_window #(
   parameter int SEL_W = 4
) (
   input  logic [SEL_W-1:0] tag,
   input  logic [SEL_W-1:0] base,
   input  logic [1:0]       mode,
   output logic             hit,
   output logic             writable
);
   import ovl_pkg::*;

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("ovl_window: SEL_W must be at least 1");
      end
   endgenerate

   always_comb begin
      hit      = mode_live(mode) && (tag == base);
      writable = mode_writable(mode);
   end
endmodule

// File: rtl/ovl_select.sv
module ovl_select #(
   parameter int N     = 2,
   parameter int IDX_W = 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   generate
      if (N < 1) begin : g_bad_n
         $error("ovl_select: N must be at least 1");
      end
   endgenerate

   // lowest index wins: scan from the top so lower indices overwrite
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/ovl_store.sv
module ovl_store #(
   parameter int AW     = 13,
   parameter int DATA_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic [AW-1:0]     addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   output logic [DATA_W-1:0] rdata_q
);
   generate
      if (LANES == 1) begin : g_byte
         localparam int DEPTH = 1 << AW;
         logic [DATA_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
         always_ff @(posedge clk) begin
            if (re) rdata_q <= mem[addr];
         end
      end else begin : g_word
         localparam int LANE_W = $clog2(LANES);
         localparam int WORD_W = LANES * DATA_W;
         localparam int DEPTH  = 1 << (AW - LANE_W);
         logic [WORD_W-1:0]   mem [DEPTH];
         logic [AW-LANE_W-1:0] word;
         logic [LANE_W-1:0]    lane;

         if ((1 << LANE_W) != LANES) begin : g_bad_lanes
            $error("ovl_store: LANES must be a power of two");
         end

         assign word = addr[AW-1:LANE_W];
         assign lane = addr[LANE_W-1:0];

         always_ff @(posedge clk) begin
            if (we) mem[word][lane*DATA_W +: DATA_W] <= wdata;
         end
         always_ff @(posedge clk) begin
            if (re) rdata_q <= mem[word][lane*DATA_W +: DATA_W];
         end
      end
   endgenerate
endmodule

// File: rtl/ovl_decoder.sv
module ovl_decoder #(
   parameter int ADDR_W    = 16,
   parameter int WIN_AW    = 12,
   parameter int NUM_BANKS = 2,
   parameter int DATA_W    = 8,
   parameter int LANES     = 4,
   localparam int SEL_W    = ADDR_W - WIN_AW,
   localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_rd,
   input  logic                         bus_wr,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic [NUM_BANKS*SEL_W-1:0]   win_base,
   input  logic [NUM_BANKS*2-1:0]       win_mode,
   output logic                         tgt_disable,
   output logic                         ram_cs,
   output logic                         ram_we,
   output logic [IDX_W-1:0]             hit_bank,
   output logic [DATA_W-1:0]            ovl_rdata,
   output logic                         ovl_rdata_oe
);
   localparam int RAM_AW = IDX_W + WIN_AW;

   generate
      if (ADDR_W <= WIN_AW) begin : g_bad_aw
         $error("ovl_decoder: ADDR_W must exceed WIN_AW");
      end
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("ovl_decoder: NUM_BANKS must be at least 1");
      end
      if (LANES < 1 || ((1 << $clog2(LANES)) != LANES)) begin : g_bad_lanes
         $error("ovl_decoder: LANES must be a power of two");
      end
   endgenerate

   logic [NUM_BANKS-1:0] hit_v;
   logic [NUM_BANKS-1:0] wr_v;
   logic                 any_hit;
   logic [IDX_W-1:0]     win_idx;
   logic                 strobe, is_rd;
   logic [RAM_AW-1:0]    ram_addr;
   logic [DATA_W-1:0]    rdata_q;
   logic                 oe_q;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
         ovl_window #(.SEL_W(SEL_W)) u_win (
            .tag      (bus_addr[ADDR_W-1:WIN_AW]),
            .base     (win_base[b*SEL_W +: SEL_W]),
            .mode     (win_mode[b*2 +: 2]),
            .hit      (hit_v[b]),
            .writable (wr_v[b])
         );
      end
   endgenerate

   ovl_select #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_sel (
      .req (hit_v),
      .any (any_hit),
      .idx (win_idx)
   );

   always_comb begin
      strobe      = bus_rd | bus_wr;
      is_rd       = bus_rd & ~bus_wr;
      tgt_disable = strobe & any_hit;
      ram_we      = tgt_disable & bus_wr & wr_v[win_idx];
      ram_cs      = tgt_disable & (is_rd | ram_we);
      hit_bank    = tgt_disable ? win_idx : '0;
      ram_addr    = {win_idx, bus_addr[WIN_AW-1:0]};
   end

   ovl_store #(.AW(RAM_AW), .DATA_W(DATA_W), .LANES(LANES)) u_store (
      .clk     (clk),
      .addr    (ram_addr),
      .we      (ram_we),
      .wdata   (bus_wdata),
      .re      (tgt_disable & is_rd),
      .rdata_q (rdata_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= tgt_disable & is_rd;
   end

   assign ovl_rdata_oe = oe_q;
   assign ovl_rdata    = oe_q ? rdata_q : '0;
endmodule

// File: rtl/ovl_decoder_chk.sv
module ovl_decoder_chk #(
   parameter int ADDR_W    = 16,
   parameter int WIN_AW    = 12,
   parameter int NUM_BANKS = 2,
   parameter int DATA_W    = 8,
   localparam int SEL_W    = ADDR_W - WIN_AW,
   localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic                       bus_rd,
   input logic                       bus_wr,
   input logic [NUM_BANKS*SEL_W-1:0] win_base,
   input logic [NUM_BANKS*2-1:0]     win_mode,
   input logic                       tgt_disable,
   input logic                       ram_cs,
   input logic                       ram_we,
   input logic [IDX_W-1:0]           hit_bank,
   input logic [DATA_W-1:0]          ovl_rdata,
   input logic                       ovl_rdata_oe
);
   import ovl_pkg::*;

   logic all_off;
   always_comb begin
      all_off = 1'b1;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (mode_live(win_mode[i*2 +: 2])) all_off = 1'b0;
      end
   end

   assert_off_never_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> !tgt_disable && !ram_cs && !ram_we);

   assert_ro_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && tgt_disable && hit_bank == '0 && win_mode[1:0] == 2'b01) |-> !ram_we && !ram_cs);

   assert_we_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> tgt_disable && bus_wr && ram_cs);

   assert_read_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_disable && bus_rd && !bus_wr) |=> ovl_rdata_oe);

   assert_valid_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_rdata_oe |-> $past(tgt_disable && bus_rd && !bus_wr));

   assert_bus_zero_when_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_rdata_oe |-> ovl_rdata == '0);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |-> !tgt_disable && !ram_cs && !ram_we);

   assert_dual_strobe_no_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr) |=> !ovl_rdata_oe);

   generate
      if (NUM_BANKS >= 2) begin : g_pri
         assert_bank_a_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((bus_rd || bus_wr) && mode_live(win_mode[1:0]) && mode_live(win_mode[3:2])
             && bus_addr[ADDR_W-1:WIN_AW] == win_base[SEL_W-1:0]
             && win_base[SEL_W-1:0] == win_base[2*SEL_W-1:SEL_W])
            |-> tgt_disable && hit_bank == '0);
      end
   endgenerate
endmodule

bind ovl_decoder ovl_decoder_chk #(
   .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .win_base(win_base), .win_mode(win_mode), .tgt_disable(tgt_disable),
   .ram_cs(ram_cs), .ram_we(ram_we), .hit_bank(hit_bank),
   .ovl_rdata(ovl_rdata), .ovl_rdata_oe(ovl_rdata_oe)
);

// File: tb/sim_ovl_decoder.sv
module sim_ovl_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [3:0]  base_a = '0, base_b = '0;
   logic [1:0]  mode_a = '0, mode_b = '0;
   logic        tgt_disable, ram_cs, ram_we, hit_bank, ovl_rdata_oe;
   logic [7:0]  ovl_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] mdl [0:8191];

   always #5 clk = ~clk;

   ovl_decoder u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .win_base({base_b, base_a}), .win_mode({mode_b, mode_a}),
      .tgt_disable(tgt_disable), .ram_cs(ram_cs), .ram_we(ram_we), .hit_bank(hit_bank),
      .ovl_rdata(ovl_rdata), .ovl_rdata_oe(ovl_rdata_oe)
   );

   function automatic logic live(input logic [1:0] m);
      return m == 2'b01 || m == 2'b10;
   endfunction

   function automatic logic [7:0] pat(input logic bank, input logic [11:0] off);
      return off[7:0] ^ {off[11:8], off[11:8]} ^ (bank ? 8'hA5 : 8'h3C);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_cycle(input string tag, input logic [15:0] a, input logic r,
                            input logic w, input logic [7:0] d);
      logic ha, hb, hit, bank, wok, e_td, e_we, e_cs, e_oe;
      logic [7:0] e_data;
      ha   = live(mode_a) && a[15:12] == base_a;
      hb   = live(mode_b) && a[15:12] == base_b;
      hit  = ha | hb;
      bank = ha ? 1'b0 : 1'b1;
      wok  = ha ? (mode_a == 2'b10) : (mode_b == 2'b10);
      e_td = (r | w) & hit;
      e_we = e_td & w & wok;
      e_cs = e_td & ((r & ~w) | e_we);
      e_oe = e_td & r & ~w;
      e_data = e_oe ? mdl[{bank, a[11:0]}] : 8'h00;
      @(negedge clk);
      bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
      #2;
      chk({tag, " tgt_disable"}, 32'(tgt_disable), 32'(e_td));
      chk({tag, " ram_we"}, 32'(ram_we), 32'(e_we));
      chk({tag, " ram_cs"}, 32'(ram_cs), 32'(e_cs));
      chk({tag, " hit_bank"}, 32'(hit_bank), 32'(e_td ? bank : 1'b0));
      @(posedge clk);
      #2;
      if (e_we) mdl[{bank, a[11:0]}] = d;
      chk({tag, " rdata_oe"}, 32'(ovl_rdata_oe), 32'(e_oe));
      chk({tag, " rdata"}, 32'(ovl_rdata), 32'(e_data));
   endtask

   task automatic idle();
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] old_b;
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      #2;
      chk("R10 reset oe", 32'(ovl_rdata_oe), 32'd0);
      chk("R10 reset data", 32'(ovl_rdata), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // fill both windows through the normal write path (R4)
      base_a = 4'h2; mode_a = 2'b10; base_b = 4'h9; mode_b = 2'b10;
      for (int i = 0; i < 4096; i++) begin
         bus_cycle("R4 fill A", {4'h2, 12'(i)}, 1'b0, 1'b1, pat(1'b0, 12'(i)));
         bus_cycle("R4 fill B", {4'h9, 12'(i)}, 1'b0, 1'b1, pat(1'b1, 12'(i)));
      end

      // separate storage at equal offset
      bus_cycle("R6 read A", 16'h2123, 1'b1, 1'b0, 8'h00);
      bus_cycle("R6 read B", 16'h9123, 1'b1, 1'b0, 8'h00);
      chk("R6 distinct", 32'(mdl[13'h0123] != mdl[13'h1123]), 32'd1);

      // read timing, back-to-back reads
      bus_cycle("R7 read", 16'h2FFF, 1'b1, 1'b0, 8'h00);
      bus_cycle("R7 read", 16'h9000, 1'b1, 1'b0, 8'h00);
      idle();
      #2;
      chk("R7 oe drops", 32'(ovl_rdata_oe), 32'd1);
      @(posedge clk); #2;
      chk("R7 oe one cycle", 32'(ovl_rdata_oe), 32'd0);

      // read-only window swallows writes
      mode_a = 2'b01;
      bus_cycle("R3 ro write", 16'h2010, 1'b0, 1'b1, 8'h55);
      bus_cycle("R3 ro readback", 16'h2010, 1'b1, 1'b0, 8'h00);
      chk("R3 old byte", 32'(mdl[13'h0010]), 32'(pat(1'b0, 12'h010)));

      // off and reserved modes
      mode_a = 2'b00;
      bus_cycle("R2 off", 16'h2010, 1'b1, 1'b0, 8'h00);
      mode_a = 2'b11;
      bus_cycle("R2 reserved", 16'h2010, 1'b0, 1'b1, 8'hEE);
      mode_a = 2'b10;
      bus_cycle("R2 reserved kept", 16'h2010, 1'b1, 1'b0, 8'h00);

      // miss and idle
      bus_cycle("R8 miss", 16'h7777, 1'b1, 1'b0, 8'h00);
      bus_cycle("R9 idle", 16'h2010, 1'b0, 1'b0, 8'h00);

      // both strobes at once act as a write
      bus_cycle("R11 dual", 16'h2020, 1'b1, 1'b1, 8'hC3);
      bus_cycle("R11 readback", 16'h2020, 1'b1, 1'b0, 8'h00);

      // overlap: A wins, B storage untouched
      old_b = mdl[13'h1AAA];
      base_a = 4'h5; base_b = 4'h5;
      bus_cycle("R5 overlap write", 16'h5AAA, 1'b0, 1'b1, 8'h99);
      bus_cycle("R5 overlap read", 16'h5AAA, 1'b1, 1'b0, 8'h00);
      base_b = 4'h6;
      bus_cycle("R5 B untouched", 16'h6AAA, 1'b1, 1'b0, 8'h00);
      chk("R5 B byte", 32'(mdl[13'h1AAA]), 32'(old_b));

      // random mix
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] a;
         logic [2:0]  op;
         if (k % 64 == 0) begin
            base_a = 4'($urandom); base_b = 4'($urandom);
            mode_a = 2'($urandom); mode_b = 2'($urandom);
            if (k % 256 == 0) base_b = base_a;
         end
         a = 16'($urandom);
         case ($urandom % 4)
            0: a[15:12] = base_a;
            1: a[15:12] = base_b;
            default: ;
         endcase
         op = 3'($urandom);
         bus_cycle("R1 random", a, op[0], op[1] & op[2], 8'($urandom));
      end

      idle();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule